// File: doc/BRIEF.md
# SDRAM Single-Write Command Sequencer

This block sits on the controller side of an SDRAM interface and carries out one single-beat write per request. A request names a bank, a row, a column, one data word and a byte mask. The sequencer opens the row with ACTIVE and waits out the row-to-column delay. It then issues WRITE with the data on DQ in that same cycle, and auto-precharge is left disabled. The row is closed with an explicit PRECHARGE. The precharge comes no earlier than the write-recovery time after the data beat. It also comes no earlier than the minimum row-active time after ACTIVE, and whichever limit falls later decides. The block then holds off the next ACTIVE until both the precharge period and the full row-cycle time have run out.

Every interval is a parameter counted in clock cycles, which is the nanosecond figure divided by the clock period and rounded up. A request is accepted only while `busy` is low. The request fields are captured at acceptance, so the requester may change them freely afterwards. `busy` drops one cycle before the earliest legal ACTIVE. A request held high through that cycle therefore opens the next row with no wasted cycle.

Top module: `sdw_seq`

## Requirements
- R1: During and after reset, `busy` is low, the command pins show NOP and `sd_dq_oe` is low.
- R2: A request sampled while `busy` is low produces ACTIVE in the next cycle, with the row zero-extended on `sd_addr` and the bank on `sd_ba`. `busy` is high from that cycle.
- R3: WRITE appears exactly T_RCD cycles after ACTIVE. In that cycle `sd_addr` carries the column zero-extended into its low COL_W bits, and bit 10 (the auto-precharge bit) and every other upper bit are low. The bank is on `sd_ba`.
- R4: In the WRITE cycle only, `sd_dq_oe` is high, `sd_dq` carries the data word and `sd_dqm` carries the byte mask. In every other cycle `sd_dq_oe` is low and `sd_dqm` is all ones.
- R5: PRECHARGE appears exactly max(T_RCD+T_WR, T_RAS) cycles after ACTIVE. `sd_addr` bit 10 equals PRE_ALL (1 closes all banks, 0 closes only the bank on `sd_ba`), and the bank is on `sd_ba`.
- R6: The command pins are ordered {cs_n, ras_n, cas_n, we_n}. ACTIVE is 0011, WRITE is 0100, PRECHARGE is 0010, and every cycle not named in R2, R3 or R5 is NOP, 0111.
- R7: Let N = max(PRE + T_RP, T_RC), where PRE is the precharge cycle of R5. `busy` stays high through cycle N-2 after ACTIVE and is low from cycle N-1, but never earlier than the cycle after PRECHARGE.
- R8: A request raised while `busy` is high is ignored. Changes to the request fields after acceptance do not alter the transaction in progress.
- R9: A request present in the first cycle `busy` is low yields the next ACTIVE exactly N cycles after the previous one.
- R10: The row is never held open beyond T_RAS_MAX cycles between ACTIVE and PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Write request strobe |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_data | input | DQ_W | Data word to write |
| req_mask | input | MASK_W | Byte mask, 1 blocks a byte |
| busy | output | 1 | Transaction in progress, requests ignored |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Multiplexed row/column address, bit 10 auto/all-bank select |
| sd_ba | output | BANK_W | Bank address |
| sd_dq | output | DQ_W | Write data |
| sd_dq_oe | output | 1 | Drive enable for DQ |
| sd_dqm | output | MASK_W | Data mask pins |

## Verification
The bench builds two copies of the block. The first uses T_RCD=3, T_WR=2, T_RAS=6, T_RP=3, T_RC=10 with PRE_ALL=1 and a 10-bit column. There the minimum row-active time decides the precharge slot and the row-cycle time decides the release of `busy`. The second uses T_RCD=2, T_WR=4, T_RAS=3, T_RP=2, T_RC=5 with PRE_ALL=0 and a 9-bit column. There write recovery decides the precharge and the precharge period decides the release, and the unused column bit 9 is shown to stay low. Between them, each branch of both maximum selections is reached, along with both precharge modes, back-to-back requests at the exact row-cycle spacing, and requests raised mid-transaction.

// File: rtl/sdw_pkg.sv
// sdw_pkg: shared types for the single-write sequencer.
// Assumes the command nibble is ordered {cs_n, ras_n, cas_n, we_n}.
package sdw_pkg;

    typedef enum logic [3:0] {
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_RCD,
        ST_WR,
        ST_REC,
        ST_PRE,
        ST_RP
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdw_cycle_ctr.sv
// sdw_cycle_ctr: counts cycles since the last ACTIVE.
// Cleared on acceptance so that it reads 0 in the ACTIVE cycle,
// it advances while run is high and saturates at LIMIT.
module sdw_cycle_ctr #(
    parameter int LIMIT = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] cnt
);

    // Elapsed-cycle register with clear and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && (int'(cnt) < LIMIT)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R7
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= LIMIT);

endmodule

// File: rtl/sdw_fsm.sv
// sdw_fsm: steps one transaction through open, write, close, recover.
// Assumes T_RCD >= 1, PRE_AT > T_RCD and IDLE_AT > PRE_AT, all supplied
// by the top. cnt is the elapsed-cycle count from sdw_cycle_ctr.
module sdw_fsm
    import sdw_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_WR      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RAS_MAX = 17143,
    parameter int PRE_AT    = 6,
    parameter int IDLE_AT   = 8,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [CNT_W-1:0] cnt,
    output seq_state_e       state,
    output logic             accept,
    output logic             busy
);

    seq_state_e state_nx;
    int         next_ofs;

    // Offset from ACTIVE that the coming cycle will have.
    always_comb next_ofs = int'(cnt) + 1;

    // Handshake view of the state.
    always_comb begin
        busy   = (state != ST_IDLE);
        accept = (state == ST_IDLE) && req;
    end

    // Next-state selection from the elapsed-cycle count.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req) state_nx = ST_ACT;
            ST_ACT, ST_RCD:
                state_nx = (next_ofs == T_RCD) ? ST_WR : ST_RCD;
            ST_WR, ST_REC:
                state_nx = (next_ofs == PRE_AT) ? ST_PRE : ST_REC;
            ST_PRE, ST_RP:
                state_nx = (next_ofs == IDLE_AT) ? ST_IDLE : ST_RP;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R3
    write_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR) |-> (int'(cnt) == T_RCD));

    // R5
    pre_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |-> ((int'(cnt) >= T_RCD + T_WR) && (int'(cnt) >= T_RAS)));

    // R10
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |-> (int'(cnt) <= T_RAS_MAX));

endmodule

// File: rtl/sdw_pins.sv
// sdw_pins: decodes the sequencer state into SDRAM pin values.
// Assumes ADDR_W >= 11 (bit 10 is the auto/all-bank select) and that
// ROW_W and COL_W do not exceed ADDR_W and 10 respectively.
module sdw_pins
    import sdw_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 10,
    parameter int BANK_W  = 2,
    parameter int DQ_W    = 16,
    parameter int MASK_W  = 2,
    parameter bit PRE_ALL = 1'b1
) (
    input  seq_state_e        state,
    input  logic [BANK_W-1:0] h_bank,
    input  logic [ROW_W-1:0]  h_row,
    input  logic [COL_W-1:0]  h_col,
    input  logic [DQ_W-1:0]   h_data,
    input  logic [MASK_W-1:0] h_mask,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic [DQ_W-1:0]   dq,
    output logic              dq_oe,
    output logic [MASK_W-1:0] dqm
);

    localparam int A10 = 10;

    sd_cmd_e cmd;

    // Per-state pin values; idle cycles default to NOP with DQ masked.
    always_comb begin
        cmd   = CMD_NOP;
        addr  = '0;
        ba    = '0;
        dq    = '0;
        dq_oe = 1'b0;
        dqm   = '1;
        unique case (state)
            ST_ACT: begin
                cmd  = CMD_ACT;
                addr = ADDR_W'(h_row);
                ba   = h_bank;
            end
            ST_WR: begin
                cmd   = CMD_WR;
                addr  = ADDR_W'(h_col);
                ba    = h_bank;
                dq    = h_data;
                dq_oe = 1'b1;
                dqm   = h_mask;
            end
            ST_PRE: begin
                cmd       = CMD_PRE;
                addr[A10] = PRE_ALL;
                ba        = h_bank;
            end
            default: ;
        endcase
    end

    // Split the command nibble onto its four pins.
    always_comb {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/sdw_seq.sv
// sdw_seq: top of the single-write SDRAM sequencer.
// Captures a request while idle, then issues ACTIVE, WRITE and a
// manual PRECHARGE at the cycle counts given by the T_* parameters
// (each ceil(ns / clock period)). Assumes T_RCD, T_WR, T_RP >= 1.
module sdw_seq
    import sdw_pkg::*;
#(
    parameter int ROW_W     = 12,
    parameter int COL_W     = 10,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 12,
    parameter int DQ_W      = 16,
    parameter int MASK_W    = 2,
    parameter int T_RCD     = 3,
    parameter int T_WR      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_RAS_MAX = 17143,
    parameter bit PRE_ALL   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DQ_W-1:0]   req_data,
    input  logic [MASK_W-1:0] req_mask,
    output logic              busy,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic [DQ_W-1:0]   sd_dq,
    output logic              sd_dq_oe,
    output logic [MASK_W-1:0] sd_dqm
);

    localparam int PRE_AT   = imax(T_RCD + T_WR, T_RAS);
    localparam int NEXT_ACT = imax(PRE_AT + T_RP, T_RC);
    localparam int IDLE_AT  = imax(NEXT_ACT - 1, PRE_AT + 1);
    localparam int CNT_W    = $clog2(IDLE_AT + 1);

    seq_state_e        state;
    logic              accept;
    logic [CNT_W-1:0]  cnt;
    logic [BANK_W-1:0] h_bank;
    logic [ROW_W-1:0]  h_row;
    logic [COL_W-1:0]  h_col;
    logic [DQ_W-1:0]   h_data;
    logic [MASK_W-1:0] h_mask;

    // Capture the request fields at acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_bank <= '0;
            h_row  <= '0;
            h_col  <= '0;
            h_data <= '0;
            h_mask <= '0;
        end else if (accept) begin
            h_bank <= req_bank;
            h_row  <= req_row;
            h_col  <= req_col;
            h_data <= req_data;
            h_mask <= req_mask;
        end
    end

    sdw_cycle_ctr #(
        .LIMIT (IDLE_AT),
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (busy),
        .cnt   (cnt)
    );

    sdw_fsm #(
        .T_RCD     (T_RCD),
        .T_WR      (T_WR),
        .T_RAS     (T_RAS),
        .T_RAS_MAX (T_RAS_MAX),
        .PRE_AT    (PRE_AT),
        .IDLE_AT   (IDLE_AT),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .cnt    (cnt),
        .state  (state),
        .accept (accept),
        .busy   (busy)
    );

    sdw_pins #(
        .ADDR_W  (ADDR_W),
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .BANK_W  (BANK_W),
        .DQ_W    (DQ_W),
        .MASK_W  (MASK_W),
        .PRE_ALL (PRE_ALL)
    ) u_pins (
        .state  (state),
        .h_bank (h_bank),
        .h_row  (h_row),
        .h_col  (h_col),
        .h_data (h_data),
        .h_mask (h_mask),
        .cs_n   (sd_cs_n),
        .ras_n  (sd_ras_n),
        .cas_n  (sd_cas_n),
        .we_n   (sd_we_n),
        .addr   (sd_addr),
        .ba     (sd_ba),
        .dq     (sd_dq),
        .dq_oe  (sd_dq_oe),
        .dqm    (sd_dqm)
    );

    // R2
    accept_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req) |=> (busy && ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_ACT)));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(h_row) && $stable(h_col) && $stable(h_bank)
                  && $stable(h_data) && $stable(h_mask)));

    // R4
    oe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |=> !sd_dq_oe);

    // R3
    write_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_WR) |-> !sd_addr[10]);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sd_dq_oe && ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_NOP)));

endmodule

// File: tb/sdw_seq_test.sv
// sdw_seq_test: self-checking bench for sdw_seq with two parameter sets.
module sdw_seq_test;

    localparam int CLK_PERIOD = 10;

    // Instance A: tRAS decides precharge, tRC decides release.
    localparam int A_RCD = 3, A_PRE = 6, A_END = 9, A_N = 10;
    // Instance B: tWR decides precharge, tRP decides release.
    localparam int B_RCD = 2, B_PRE = 6, B_END = 7, B_N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_a = 1'b0, req_b = 1'b0;
    logic [1:0]  i_bank = '0;
    logic [11:0] i_row = '0;
    logic [9:0]  i_col = '0;
    logic [15:0] i_data = '0;
    logic [1:0]  i_mask = '0;
    logic sel = 1'b0;

    logic busy_a, cs_a, ras_a, cas_a, we_a, oe_a;
    logic [11:0] addr_a; logic [1:0] ba_a; logic [15:0] dq_a; logic [1:0] dqm_a;
    logic busy_b, cs_b, ras_b, cas_b, we_b, oe_b;
    logic [11:0] addr_b; logic [1:0] ba_b; logic [15:0] dq_b; logic [1:0] dqm_b;

    logic o_busy, o_oe;
    logic [3:0] o_cmd; logic [11:0] o_addr; logic [1:0] o_ba; logic [15:0] o_dq; logic [1:0] o_dqm;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int last_act = 0;
    bit last_sel = 1'b0, have_last = 1'b0, done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdw_seq #(.T_RCD(3), .T_WR(2), .T_RAS(6), .T_RP(3), .T_RC(10),
              .PRE_ALL(1'b1), .COL_W(10)) uut (
        .clk(clk), .rst_n(rst_n), .req(req_a), .req_bank(i_bank), .req_row(i_row),
        .req_col(i_col), .req_data(i_data), .req_mask(i_mask), .busy(busy_a),
        .sd_cs_n(cs_a), .sd_ras_n(ras_a), .sd_cas_n(cas_a), .sd_we_n(we_a),
        .sd_addr(addr_a), .sd_ba(ba_a), .sd_dq(dq_a), .sd_dq_oe(oe_a), .sd_dqm(dqm_a));

    sdw_seq #(.T_RCD(2), .T_WR(4), .T_RAS(3), .T_RP(2), .T_RC(5),
              .PRE_ALL(1'b0), .COL_W(9)) uut_b (
        .clk(clk), .rst_n(rst_n), .req(req_b), .req_bank(i_bank), .req_row(i_row),
        .req_col(i_col[8:0]), .req_data(i_data), .req_mask(i_mask), .busy(busy_b),
        .sd_cs_n(cs_b), .sd_ras_n(ras_b), .sd_cas_n(cas_b), .sd_we_n(we_b),
        .sd_addr(addr_b), .sd_ba(ba_b), .sd_dq(dq_b), .sd_dq_oe(oe_b), .sd_dqm(dqm_b));

    always_comb begin
        if (sel) begin
            o_busy = busy_b; o_cmd = {cs_b, ras_b, cas_b, we_b}; o_addr = addr_b;
            o_ba = ba_b; o_dq = dq_b; o_oe = oe_b; o_dqm = dqm_b;
        end else begin
            o_busy = busy_a; o_cmd = {cs_a, ras_a, cas_a, we_a}; o_addr = addr_a;
            o_ba = ba_a; o_dq = dq_a; o_oe = oe_a; o_dqm = dqm_a;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_req(input bit s, input logic v);
        if (s) req_b = v; else req_a = v;
    endtask

    function automatic int rcd_of(input bit s); return s ? B_RCD : A_RCD; endfunction
    function automatic int pre_of(input bit s); return s ? B_PRE : A_PRE; endfunction
    function automatic int end_of(input bit s); return s ? B_END : A_END; endfunction
    function automatic int n_of(input bit s);   return s ? B_N : A_N; endfunction
    function automatic logic [11:0] col_exp(input bit s, input logic [9:0] c);
        return s ? {3'b0, c[8:0]} : {2'b0, c};
    endfunction

    // One full transaction; gap = idle cycles before the request.
    task automatic txn(input bit s, input logic [1:0] b, input logic [11:0] r,
                       input logic [9:0] c, input logic [15:0] d, input logic [1:0] m,
                       input bit intrude, input int gap);
        bit waited = 1'b0;
        sel = s;
        repeat (gap) @(negedge clk);
        while (o_busy) begin waited = 1'b1; @(negedge clk); end
        i_bank = b; i_row = r; i_col = c; i_data = d; i_mask = m;
        set_req(s, 1'b1);
        @(negedge clk);
        set_req(s, 1'b0);
        if (have_last && last_sel == s && gap == 0 && !waited)
            chk("R9", "ACTIVE spacing", 32'(cyc - last_act), 32'(n_of(s)));
        last_act = cyc; last_sel = s; have_last = 1'b1;
        for (int off = 0; off <= end_of(s); off++) begin
            if (off == 0) begin
                chk("R2", "cmd ACTIVE", o_cmd, 4'b0011);
                chk("R2", "row", o_addr, r);
                chk("R2", "bank", o_ba, b);
            end else if (off == rcd_of(s)) begin
                chk("R3", "cmd WRITE", o_cmd, 4'b0100);
                chk("R3", "column addr A10 low", o_addr, col_exp(s, c));
                chk("R3", "bank", o_ba, b);
                chk("R4", "dq_oe", o_oe, 1'b1);
                chk("R4", "dq", o_dq, d);
                chk("R4", "dqm", o_dqm, m);
            end else if (off == pre_of(s)) begin
                chk("R5 R10", "cmd PRECHARGE", o_cmd, 4'b0010);
                chk("R5", "A10 all-banks", o_addr[10], s ? 1'b0 : 1'b1);
                chk("R5", "bank", o_ba, b);
            end else begin
                chk("R6", "cmd NOP", o_cmd, 4'b0111);
            end
            if (off != rcd_of(s)) begin
                chk("R4", "dq_oe idle", o_oe, 1'b0);
                chk("R4", "dqm idle", o_dqm, 2'b11);
            end
            chk("R7", "busy", o_busy, (off < end_of(s)) ? 1'b1 : 1'b0);
            if (intrude && off == 1) begin
                i_bank = ~b; i_row = ~r; i_col = ~c; i_data = ~d; i_mask = ~m;
                set_req(s, 1'b1);
            end
            if (intrude && off == 2) begin
                set_req(s, 1'b0);
                chk("R8", "ignored request keeps busy", o_busy, 1'b1);
            end
            if (off < end_of(s)) @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0001));
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset A", busy_a, 1'b0);
        chk("R1", "cmd in reset A", {cs_a, ras_a, cas_a, we_a}, 4'b0111);
        chk("R1", "oe in reset B", oe_b, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset B", busy_b, 1'b0);
        chk("R1", "cmd after reset B", {cs_b, ras_b, cas_b, we_b}, 4'b0111);
        chk("R1", "oe after reset A", oe_a, 1'b0);

        // Directed corners.
        txn(1'b0, 2'd1, 12'hABC, 10'h3FF, 16'hA55A, 2'b01, 1'b0, 0);
        txn(1'b0, 2'd2, 12'h123, 10'h155, 16'h1234, 2'b10, 1'b1, 0);
        txn(1'b0, 2'd3, 12'hFFF, 10'h000, 16'hFFFF, 2'b00, 1'b0, 0);
        txn(1'b1, 2'd0, 12'h800, 10'h3FF, 16'h0F0F, 2'b11, 1'b0, 2);
        txn(1'b1, 2'd3, 12'h001, 10'h200, 16'hF00F, 2'b00, 1'b1, 0);
        txn(1'b1, 2'd1, 12'h555, 10'h1AA, 16'h8001, 2'b01, 1'b0, 0);

        // Random mix.
        for (int k = 0; k < 40; k++) begin
            txn(1'($urandom), 2'($urandom), 12'($urandom), 10'($urandom),
                16'($urandom), 2'($urandom), 1'($urandom), int'($urandom % 3));
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule